// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block follows a processor bus cycle on the processor clock and drives a ready line that stretches the cycle by a number of wait states. The number depends on the kind of cycle and on where the address falls. A memory read, a memory write or an interrupt acknowledge is identified from three active-low strobes. The address is taken from a 20-bit bus while the address latch enable is high.

The ready line starts each cycle not-ready. It rises only once enough clocks have passed since the generator was let go from its start state. A late ready can therefore only add a wait state and can never remove one. The start state is held either while the address latch enable is high or, in the other build variant, while all three strobes are idle. The variant is chosen by a parameter. Each kind of cycle in each of the two address windows has its own wait count, and each count is a parameter.

The processor samples ready at the end of T3 and at the end of each wait state. The wait count of a cycle is the number of such samples that see ready low. After T4 the level of ready does not matter until T3 of the next cycle.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is asserted, ready is low.
- R2: For addresses whose bits [19:16] equal 0x8, a read cycle gets 1 wait state and a write cycle gets 2.
- R3: For addresses whose bits [19:16] equal 0x9, a read cycle gets 2 wait states and a write cycle gets 1.
- R4: An interrupt-acknowledge cycle gets 2 wait states whatever the address. When more than one strobe is active, interrupt acknowledge has priority over write, and write has priority over read.
- R5: An address outside both windows gets 0 wait states, so ready is already high at the first sample in T3.
- R6: In the clock after the start-hold condition was true, ready is low. Ready is therefore low throughout T2 of every cycle.
- R7: With INIT_FROM_STROBES=0, the hold condition is ale high. With INIT_FROM_STROBES=1, it is rd_n, wr_n and inta_n all high. Both variants give the same wait counts.
- R8: The address is captured on every clock where ale is high and is held after ale falls. Address changes after that point have no effect on the wait count.
- R9: Once ready has risen within a cycle, it stays high until the hold condition returns. In particular, it is still high during T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable, high during T1 |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| inta_n | input | 1 | Interrupt-acknowledge strobe, active low |
| addr | input | 20 | Bus address, valid while ale is high |
| ready | output | 1 | High when the processor may end the cycle |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the defaults, INIT_FROM_STROBES=0 with the 1/2, 2/1 and 2 wait counts. The other uses INIT_FROM_STROBES=1, so both start-hold variants are compared on every cycle. With the default window tags 0x8 and 0x9, the edge addresses 0x7FFFF, 0x80000, 0x8FFFF, 0x90000, 0x9FFFF and 0xA0000 can be reached, as can the priority among overlapping strobes and a deliberate address change in T2.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_INTA  = 2'd2
    } bwg_kind_e;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_A    = 2'd1,
        WIN_B    = 2'd2
    } bwg_win_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bwg_capture.sv
module bwg_capture
    import bwg_pkg::*;
#(
    parameter int ADDR_W            = 20,
    parameter bit INIT_FROM_STROBES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              inta_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_held,
    output bwg_kind_e         kind_eff,
    output logic              hold
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        bwg_kind_e         kind;
        logic              vld;
    } cap_t;

    cap_t      cap_d, cap_q;
    bwg_kind_e kind_live;
    logic      any_strobe;

    generate
        if (INIT_FROM_STROBES) begin : g_hold_strb
            assign hold = rd_n & wr_n & inta_n;
        end else begin : g_hold_ale
            assign hold = ale;
        end
    endgenerate

    always_comb begin
        any_strobe = ~(rd_n & wr_n & inta_n);
        if (!inta_n)     kind_live = KIND_INTA;
        else if (!wr_n)  kind_live = KIND_WRITE;
        else             kind_live = KIND_READ;

        cap_d = cap_q;
        if (ale) cap_d.addr = addr;
        if (hold) begin
            cap_d.vld = 1'b0;
        end else if (!cap_q.vld && any_strobe) begin
            cap_d.vld  = 1'b1;
            cap_d.kind = kind_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '{addr: '0, kind: KIND_READ, vld: 1'b0};
        else        cap_q <= cap_d;
    end

    assign addr_held = cap_q.addr;
    assign kind_eff  = cap_q.vld ? cap_q.kind : kind_live;

endmodule

// File: rtl/bwg_window_decode.sv
module bwg_window_decode
    import bwg_pkg::*;
#(
    parameter int              ADDR_W = 20,
    parameter int              TAG_W  = 4,
    parameter logic [TAG_W-1:0] TAG_A = 4'h8,
    parameter logic [TAG_W-1:0] TAG_B = 4'h9
) (
    input  logic [ADDR_W-1:0] addr,
    output bwg_win_e          win
);

    logic [TAG_W-1:0] tag;

    always_comb begin
        tag = addr[ADDR_W-1 -: TAG_W];
        if (tag == TAG_A)      win = WIN_A;
        else if (tag == TAG_B) win = WIN_B;
        else                   win = WIN_NONE;
    end

endmodule

// File: rtl/bwg_wait_select.sv
module bwg_wait_select
    import bwg_pkg::*;
#(
    parameter int WAIT_W    = 2,
    parameter int RD_WAIT_A = 1,
    parameter int WR_WAIT_A = 2,
    parameter int RD_WAIT_B = 2,
    parameter int WR_WAIT_B = 1,
    parameter int INTA_WAIT = 2
) (
    input  bwg_win_e          win,
    input  bwg_kind_e         kind,
    output logic [WAIT_W-1:0] waits
);

    always_comb begin
        waits = '0;
        if (kind == KIND_INTA) begin
            waits = WAIT_W'(INTA_WAIT);
        end else begin
            unique case (win)
                WIN_A:   waits = (kind == KIND_WRITE) ? WAIT_W'(WR_WAIT_A) : WAIT_W'(RD_WAIT_A);
                WIN_B:   waits = (kind == KIND_WRITE) ? WAIT_W'(WR_WAIT_B) : WAIT_W'(RD_WAIT_B);
                default: waits = '0;
            endcase
        end
    end

endmodule

// File: rtl/bwg_ready_seq.sv
module bwg_ready_seq #(
    parameter int WAIT_W   = 2,
    parameter int MAX_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [WAIT_W-1:0] waits,
    output logic              ready
);

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
        logic              rdy;
    } seq_t;

    localparam logic [WAIT_W-1:0] CNT_TOP = WAIT_W'(MAX_WAIT);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (hold) begin
            seq_d.cnt = '0;
            seq_d.rdy = 1'b0;
        end else begin
            seq_d.rdy = (seq_q.cnt >= waits);
            if (seq_q.cnt != CNT_TOP) seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{cnt: '0, rdy: 1'b0};
        else        seq_q <= seq_d;
    end

    assign ready = seq_q.rdy;

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import bwg_pkg::*;
#(
    parameter int              ADDR_W            = 20,
    parameter int              TAG_W             = 4,
    parameter logic [TAG_W-1:0] TAG_A            = 4'h8,
    parameter logic [TAG_W-1:0] TAG_B            = 4'h9,
    parameter int              RD_WAIT_A         = 1,
    parameter int              WR_WAIT_A         = 2,
    parameter int              RD_WAIT_B         = 2,
    parameter int              WR_WAIT_B         = 1,
    parameter int              INTA_WAIT         = 2,
    parameter bit              INIT_FROM_STROBES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              inta_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready
);

    localparam int MAX_WAIT = max2(max2(max2(RD_WAIT_A, WR_WAIT_A),
                                        max2(RD_WAIT_B, WR_WAIT_B)), INTA_WAIT);
    localparam int WAIT_W   = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

    logic [ADDR_W-1:0] addr_w;
    bwg_kind_e         kind_w;
    bwg_win_e          win_w;
    logic [WAIT_W-1:0] waits_w;
    logic              hold_w;

    bwg_capture #(.ADDR_W(ADDR_W), .INIT_FROM_STROBES(INIT_FROM_STROBES)) u_cap (
        .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .addr(addr), .addr_held(addr_w), .kind_eff(kind_w),
        .hold(hold_w)
    );

    bwg_window_decode #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .TAG_A(TAG_A), .TAG_B(TAG_B)) u_dec (
        .addr(addr_w), .win(win_w)
    );

    bwg_wait_select #(
        .WAIT_W(WAIT_W), .RD_WAIT_A(RD_WAIT_A), .WR_WAIT_A(WR_WAIT_A),
        .RD_WAIT_B(RD_WAIT_B), .WR_WAIT_B(WR_WAIT_B), .INTA_WAIT(INTA_WAIT)
    ) u_sel (
        .win(win_w), .kind(kind_w), .waits(waits_w)
    );

    bwg_ready_seq #(.WAIT_W(WAIT_W), .MAX_WAIT(MAX_WAIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .hold(hold_w), .waits(waits_w), .ready(ready)
    );

endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
    parameter int WAIT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              ready,
    input logic [WAIT_W-1:0] waits
);

    // R6: a held start state leaves ready low in the next clock
    assert_hold_forces_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !ready);

    // R6: ready only rises after a clock out of the hold state
    assert_rise_needs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !$past(hold));

    // R9: once raised, ready stays high while not held
    assert_ready_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !hold) |=> ready);

    // R5: a zero wait count raises ready right after release
    assert_zero_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold) && waits == '0) |=> ready);

    // R1: ready low during reset
    always_comb begin
        if (!rst_n) assert_reset_low_R1: assert (!ready);
    end

endmodule

bind bus_wait_gen bwg_checker #(.WAIT_W(WAIT_W)) u_bwg_checker (
    .clk(clk), .rst_n(rst_n), .hold(hold_w), .ready(ready), .waits(waits_w)
);

// File: tb/bus_wait_gen_test.sv
`timescale 1ns/1ps
module bus_wait_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        inta_n = 1'b1;
    logic [19:0] addr = '0;
    logic        ready_a, ready_s;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    bus_wait_gen uut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .addr(addr), .ready(ready_a)
    );

    bus_wait_gen #(.INIT_FROM_STROBES(1'b1)) uut_strb (
        .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .addr(addr), .ready(ready_s)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 read, 1 write, 2 interrupt acknowledge, 3 write and read together
    task automatic bus_cycle(input string req, input int kind, input logic [19:0] a_t1,
                             input logic [19:0] a_t2, input int exp);
        int wa = 0;
        int ws = 0;
        bit da = 0;
        bit ds = 0;
        @(negedge clk);                       // T1
        ale = 1'b1; addr = a_t1; rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
        @(negedge clk);                       // T2
        ale = 1'b0; addr = a_t2;
        case (kind)
            0: rd_n = 1'b0;
            1: wr_n = 1'b0;
            2: inta_n = 1'b0;
            default: begin wr_n = 1'b0; rd_n = 1'b0; end
        endcase
        #1;
        check({req, " R6 ready low in T2 (ale variant)"}, int'(ready_a), 0);
        check({req, " R6 ready low in T2 (strobe variant)"}, int'(ready_s), 0);
        for (int i = 0; i < 10 && !(da && ds); i++) begin
            @(negedge clk);                   // T3 then wait states
            if (!da) begin if (ready_a) da = 1; else wa++; end
            if (!ds) begin if (ready_s) ds = 1; else ws++; end
        end
        check({req, " wait count (ale variant)"}, wa, exp);
        check({req, " R7 wait count (strobe variant)"}, ws, exp);
        @(negedge clk);                       // T4
        check({req, " R9 ready kept high in T4 (ale variant)"}, int'(ready_a), 1);
        check({req, " R9 ready kept high in T4 (strobe variant)"}, int'(ready_s), 1);
        @(negedge clk);                       // idle
        rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
    endtask

    task automatic test_reset();
        #1;
        check("R1 ready during reset (ale variant)", int'(ready_a), 0);
        check("R1 ready during reset (strobe variant)", int'(ready_s), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_window_a();
        bus_cycle("R2 read 0x80000",  0, 20'h80000, 20'h80000, 1);
        bus_cycle("R2 write 0x80010", 1, 20'h80010, 20'h80010, 2);
        bus_cycle("R2 read 0x8FFFF",  0, 20'h8FFFF, 20'h8FFFF, 1);
    endtask

    task automatic test_window_b();
        bus_cycle("R3 read 0x90000",  0, 20'h90000, 20'h90000, 2);
        bus_cycle("R3 write 0x9FFFF", 1, 20'h9FFFF, 20'h9FFFF, 1);
    endtask

    task automatic test_inta();
        bus_cycle("R4 inta outside address", 2, 20'h12345, 20'h12345, 2);
        bus_cycle("R4 inta window A address", 2, 20'h80000, 20'h80000, 2);
        bus_cycle("R4 write priority over read in window A", 3, 20'h84000, 20'h84000, 2);
    endtask

    task automatic test_outside();
        bus_cycle("R5 read 0x7FFFF",  0, 20'h7FFFF, 20'h7FFFF, 0);
        bus_cycle("R5 write 0xA0000", 1, 20'hA0000, 20'hA0000, 0);
    endtask

    task automatic test_addr_hold();
        bus_cycle("R8 window A read, address moved in T2",  0, 20'h80004, 20'h00004, 1);
        bus_cycle("R8 outside write, address moved in T2",  1, 20'h30000, 20'h90000, 0);
    endtask

    initial begin
        test_reset();
        test_window_a();
        test_window_b();
        test_inta();
        test_outside();
        test_addr_hold();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=below 100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule